// File: doc/BRIEF.md
# Receive DMA Overrun Responder

This block sits between a USB packet engine and the DMA write path of an endpoint controller. It watches the received byte stream and handles two kinds of overrun. A packet can run longer than the endpoint's maximum size. The bus master can also fail to keep up with memory, which is a latency overrun. For each received byte the block decides whether the byte may reach memory, and it gives the byte's offset in the buffer. Once the payload passes the maximum packet size, later bytes are dropped, so memory next to the buffer is never overwritten.

When a packet ends, the block sets a sticky DMA error flag if either error occurred. It can also raise an interrupt. It then decides whether the buffer descriptor is updated and a token-done event is issued, and with which PID and length. The answer depends on the operating mode. In device mode, a latency overrun is dropped silently, because a retry is expected to follow. In host mode, a latency overrun is reported with the reserved PID code 4'b1111. An oversize packet is reported in both modes, with the real token PID and the clipped length.

The control is a three-state machine. ST_IDLE waits for a byte. ST_RECV means a packet is in progress. ST_REPORT is the one cycle in which the result of the finished packet is presented. The transitions are as follows. IDLE or REPORT go to RECV on a byte without end marker ("start"). IDLE or REPORT go to REPORT on a one-byte packet ("single"). RECV goes to REPORT on the byte that carries the end marker ("finish"). REPORT goes to IDLE when no byte arrives ("retire"). RECV holds while the packet continues.

Top module: `usb_dma_overrun_resp`

## Requirements
- R1: `mem_we` is high for a received byte only while fewer than `max_pkt` bytes of the current packet have been stored. `mem_offset` gives the number of bytes already stored in this packet.
- R2: For an oversize packet without latency overrun, `wb_len` in the report cycle equals `max_pkt`.
- R3: `dma_err_stat` becomes 1 in the cycle after the end byte of any packet with either error, in host or device mode. It then stays 1 until a cycle with `stat_wr`=1 and `stat_wdata`=1. A write of 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R4: `err_irq` pulses in the report cycle of an errored packet only when `dma_err_en` and `err_int_en` are both 1 in that cycle.
- R5: An oversize packet without latency overrun gives `tok_done`=1 and `wb_valid`=1, with `wb_pid` equal to the `tok_pid` presented with the end byte. This PID is not forced to 4'b1111.
- R6: A latency overrun in host mode (`host_mode`=1 at the end byte) gives `tok_done`=1 and `wb_valid`=1, with `wb_pid`=4'b1111 and `wb_len` equal to the bytes stored.
- R7: A latency overrun in device mode gives neither `wb_valid` nor `tok_done`, although `dma_err_stat` is still set.
- R8: The stored-byte count restarts with every packet, so the first byte after an end byte is written at `mem_offset` 0.
- R9: `tok_done`, `wb_valid` and `err_irq` are single-cycle pulses, high only in the cycle after an end byte. A clean packet reports its real PID and full length, with no error.
- R10: When a packet has both a latency overrun and an oversize condition, the latency rules of R6 and R7 apply.
- R11: After reset, `tok_done`, `wb_valid`, `err_irq`, `dma_err_stat` and `mem_we` are all 0.
- R12: `lat_err` counts only while a packet is in progress, meaning in a byte cycle or between bytes of an unfinished packet. Outside a packet it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | 1 = host, 0 = device |
| max_pkt | input | LEN_W | Endpoint maximum packet size in bytes |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | With rx_valid: this byte ends the packet |
| tok_pid | input | 4 | PID of the current token |
| lat_err | input | 1 | Memory latency overrun indication |
| dma_err_en | input | 1 | DMA error interrupt enable |
| err_int_en | input | 1 | Error interrupt group enable |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 1 | Write-one-to-clear value for the DMA error bit |
| mem_we | output | 1 | Byte write enable toward memory |
| mem_offset | output | LEN_W | Byte offset of the write in the buffer |
| mem_data | output | 8 | Byte to write |
| wb_valid | output | 1 | Descriptor write-back strobe |
| wb_pid | output | 4 | PID field for the descriptor |
| wb_len | output | LEN_W | Length field for the descriptor |
| tok_done | output | 1 | Token-done event pulse |
| dma_err_stat | output | 1 | Sticky DMA error status |
| err_irq | output | 1 | DMA error interrupt pulse |

## Verification
The bench runs packets shorter than, equal to and longer than the maximum size, with sizes of 0 and 1 as extremes. These tell correct clipping apart from off-by-one clipping, and show that the count restarts per packet. Latency overruns are injected mid-packet, on the end byte and between packets, in both modes and together with oversize. This separates the host report, the silent device drop, the priority of latency over oversize, and the rule that overruns outside a packet are ignored. The enable pairs and the status writes of 0, 1 and set-with-clear separate the interrupt gating from the sticky flag.

// File: rtl/usbovr_pkg.sv
package usbovr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_REPORT = 2'd2
    } ovr_state_e;

    localparam logic [3:0] PID_LATENCY = 4'b1111;

endpackage

// File: rtl/ovr_clip_ctr.sv
module ovr_clip_ctr #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             eop_beat,
    input  logic [LEN_W-1:0] max_pkt,
    output logic             we,
    output logic [LEN_W-1:0] offset,
    output logic             over_beat,
    output logic [LEN_W-1:0] stored_after
);

    logic [LEN_W-1:0] cnt_q;
    logic             room;

    assign room         = (cnt_q < max_pkt);
    assign we           = beat && room;
    assign over_beat    = beat && !room;
    assign offset       = cnt_q;
    assign stored_after = cnt_q + {{(LEN_W-1){1'b0}}, we};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (eop_beat) begin
            cnt_q <= '0;
        end else if (we) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ovr_err_status.sv
module ovr_err_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr,
    input  logic wdata,
    output logic stat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= 1'b0;
        end else if (set) begin
            stat <= 1'b1;
        end else if (wr && wdata) begin
            stat <= 1'b0;
        end
    end

    // R3: sticky unless a write-one arrives without a concurrent set
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !(wr && wdata)) |=> stat);

    a_r3_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> stat);

endmodule

// File: rtl/ovr_resp_fsm.sv
module ovr_resp_fsm
    import usbovr_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             eop,
    input  logic             lat_err,
    input  logic             host_mode,
    input  logic [3:0]       tok_pid,
    input  logic             over_beat,
    input  logic [LEN_W-1:0] stored_after,
    input  logic             dma_err_en,
    input  logic             err_int_en,
    output logic             eop_beat,
    output logic             err_set,
    output logic             wb_valid,
    output logic             tok_done,
    output logic [3:0]       wb_pid,
    output logic [LEN_W-1:0] wb_len,
    output logic             err_irq
);

    ovr_state_e       state_q, state_d;
    logic             lat_q, over_q;
    logic             in_pkt, lat_now, over_now;
    logic             r_lat, r_err, r_host;
    logic [3:0]       r_pid;
    logic [LEN_W-1:0] r_len;

    assign eop_beat = beat && eop;
    assign in_pkt   = beat || (state_q == ST_RECV);
    assign lat_now  = lat_q || (lat_err && in_pkt);
    assign over_now = over_q || over_beat;
    assign err_set  = eop_beat && (lat_now || over_now);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_REPORT: begin
                if (beat) state_d = eop ? ST_REPORT : ST_RECV;
                else      state_d = ST_IDLE;
            end
            ST_RECV: begin
                if (eop_beat) state_d = ST_REPORT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-packet error tracking and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= 1'b0;
            over_q <= 1'b0;
            r_lat  <= 1'b0;
            r_err  <= 1'b0;
            r_host <= 1'b0;
            r_pid  <= '0;
            r_len  <= '0;
        end else if (eop_beat) begin
            lat_q  <= 1'b0;
            over_q <= 1'b0;
            r_lat  <= lat_now;
            r_err  <= lat_now || over_now;
            r_host <= host_mode;
            r_pid  <= tok_pid;
            r_len  <= stored_after;
        end else begin
            lat_q  <= lat_now;
            over_q <= over_now;
        end
    end

    // outputs
    always_comb begin
        wb_valid = 1'b0;
        tok_done = 1'b0;
        err_irq  = 1'b0;
        wb_pid   = r_lat ? PID_LATENCY : r_pid;
        wb_len   = r_len;
        unique case (state_q)
            ST_REPORT: begin
                wb_valid = !(r_lat && !r_host);
                tok_done = !(r_lat && !r_host);
                err_irq  = r_err && dma_err_en && err_int_en;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/usb_dma_overrun_resp.sv
module usb_dma_overrun_resp #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_mode,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_eop,
    input  logic [3:0]       tok_pid,
    input  logic             lat_err,
    input  logic             dma_err_en,
    input  logic             err_int_en,
    input  logic             stat_wr,
    input  logic             stat_wdata,
    output logic             mem_we,
    output logic [LEN_W-1:0] mem_offset,
    output logic [7:0]       mem_data,
    output logic             wb_valid,
    output logic [3:0]       wb_pid,
    output logic [LEN_W-1:0] wb_len,
    output logic             tok_done,
    output logic             dma_err_stat,
    output logic             err_irq
);

    logic             eop_beat, over_beat, err_set;
    logic [LEN_W-1:0] stored_after;

    assign mem_data = rx_data;

    ovr_clip_ctr #(.LEN_W(LEN_W)) u_clip (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat         (rx_valid),
        .eop_beat     (eop_beat),
        .max_pkt      (max_pkt),
        .we           (mem_we),
        .offset       (mem_offset),
        .over_beat    (over_beat),
        .stored_after (stored_after)
    );

    ovr_resp_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat         (rx_valid),
        .eop          (rx_eop),
        .lat_err      (lat_err),
        .host_mode    (host_mode),
        .tok_pid      (tok_pid),
        .over_beat    (over_beat),
        .stored_after (stored_after),
        .dma_err_en   (dma_err_en),
        .err_int_en   (err_int_en),
        .eop_beat     (eop_beat),
        .err_set      (err_set),
        .wb_valid     (wb_valid),
        .tok_done     (tok_done),
        .wb_pid       (wb_pid),
        .wb_len       (wb_len),
        .err_irq      (err_irq)
    );

    ovr_err_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .wr    (stat_wr),
        .wdata (stat_wdata),
        .stat  (dma_err_stat)
    );

    // R4: interrupt only with the error flag raised and both enables on
    a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (dma_err_stat && dma_err_en && err_int_en));

    // R6: host-mode latency overrun reported with the reserved PID
    a_r6_host_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eop && lat_err && host_mode) |=> (tok_done && wb_pid == 4'b1111));

    // R7: device-mode latency overrun is silent
    a_r7_dev_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eop && lat_err && !host_mode) |=> (!tok_done && !wb_valid));

    // R8: counting restarts after every end byte
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eop) |=> (mem_offset == '0));

    // R9: report pulses only follow an end byte
    a_r9_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_done || err_irq) |-> $past(rx_valid && rx_eop));

    // R1: nothing is written at or beyond the size limit
    a_r1_clip: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mem_offset >= max_pkt) |-> !mem_we);

endmodule

// File: tb/usb_dma_overrun_resp_bench.sv
module usb_dma_overrun_resp_bench;

    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_mode = 1'b1;
    logic [LEN_W-1:0] max_pkt = 11'd8;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_data = 8'h00;
    logic             rx_eop = 1'b0;
    logic [3:0]       tok_pid = 4'h1;
    logic             lat_err = 1'b0;
    logic             dma_err_en = 1'b1;
    logic             err_int_en = 1'b1;
    logic             stat_wr = 1'b0;
    logic             stat_wdata = 1'b0;
    logic             mem_we;
    logic [LEN_W-1:0] mem_offset;
    logic [7:0]       mem_data;
    logic             wb_valid;
    logic [3:0]       wb_pid;
    logic [LEN_W-1:0] wb_len;
    logic             tok_done;
    logic             dma_err_stat;
    logic             err_irq;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    int    m_cnt = 0;
    bit    m_inpkt = 0, m_lat = 0, m_over = 0, m_stat = 0;
    bit    m_rep = 0, m_rep_wb = 0, m_rep_err = 0;
    int    m_rep_pid = 0, m_rep_len = 0;
    string m_rep_tag = "R9";

    always #10 clk = ~clk;

    usb_dma_overrun_resp #(.LEN_W(LEN_W)) u_usb_dma_overrun_resp (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .max_pkt(max_pkt),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .tok_pid(tok_pid),
        .lat_err(lat_err), .dma_err_en(dma_err_en), .err_int_en(err_int_en),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .mem_we(mem_we),
        .mem_offset(mem_offset), .mem_data(mem_data), .wb_valid(wb_valid),
        .wb_pid(wb_pid), .wb_len(wb_len), .tok_done(tok_done),
        .dma_err_stat(dma_err_stat), .err_irq(err_irq)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare mid-low-phase, advance model at posedge
    task automatic cycle(input bit v, input bit e, input bit l);
        bit we, eop, latn, overn;
        rx_valid = v; rx_eop = e; lat_err = l;
        rx_data  = 8'(m_cnt * 3 + 5);
        #2;
        we = v && (m_cnt < int'(max_pkt));
        chk(mem_we == we, "R1", "mem_we", int'(mem_we), int'(we));
        if (we) begin
            chk(int'(mem_offset) == m_cnt, "R1", "mem_offset", int'(mem_offset), m_cnt);
            chk(mem_data == rx_data, "R1", "mem_data", int'(mem_data), int'(rx_data));
        end
        chk(tok_done == (m_rep && m_rep_wb), m_rep_tag, "tok_done",
            int'(tok_done), int'(m_rep && m_rep_wb));
        chk(wb_valid == (m_rep && m_rep_wb), m_rep_tag, "wb_valid",
            int'(wb_valid), int'(m_rep && m_rep_wb));
        if (m_rep && m_rep_wb) begin
            chk(int'(wb_pid) == m_rep_pid, m_rep_tag, "wb_pid", int'(wb_pid), m_rep_pid);
            chk(int'(wb_len) == m_rep_len, m_rep_tag, "wb_len", int'(wb_len), m_rep_len);
        end
        chk(err_irq == (m_rep && m_rep_err && dma_err_en && err_int_en), "R4", "err_irq",
            int'(err_irq), int'(m_rep && m_rep_err && dma_err_en && err_int_en));
        chk(dma_err_stat == m_stat, "R3", "dma_err_stat", int'(dma_err_stat), int'(m_stat));
        @(posedge clk);
        eop   = v && e;
        latn  = m_lat || (l && (v || m_inpkt));
        overn = m_over || (v && m_cnt >= int'(max_pkt));
        if (eop && (latn || overn)) m_stat = 1;
        else if (stat_wr && stat_wdata) m_stat = 0;
        if (eop) begin
            m_rep     = 1;
            m_rep_wb  = !(latn && !host_mode);
            m_rep_err = latn || overn;
            m_rep_pid = latn ? 15 : int'(tok_pid);
            m_rep_len = m_cnt + int'(we);
            if (latn && overn)   m_rep_tag = "R10";
            else if (latn)       m_rep_tag = host_mode ? "R6" : "R7";
            else if (overn)      m_rep_tag = "R5";
            else                 m_rep_tag = "R9";
            if (overn && !latn)  m_rep_tag = (m_rep_len == int'(max_pkt)) ? "R5" : "R2";
            m_cnt = 0; m_lat = 0; m_over = 0; m_inpkt = 0;
        end else begin
            m_rep = 0;
            m_cnt = m_cnt + int'(we);
            m_lat = latn; m_over = overn; m_inpkt = v || m_inpkt;
        end
        @(negedge clk);
    endtask

    task automatic packet(input int n, input int lat_at);
        for (int i = 0; i < n; i++) cycle(1'b1, i == n - 1, i == lat_at);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #4_000_000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R11: reset state
        chk(!tok_done && !wb_valid && !err_irq, "R11", "report outputs in reset",
            int'(tok_done || wb_valid || err_irq), 0);
        chk(!dma_err_stat, "R11", "status in reset", int'(dma_err_stat), 0);
        chk(!mem_we, "R11", "mem_we in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: clean packets, host then device
        host_mode = 1; max_pkt = 8; tok_pid = 4'h1;
        packet(4, -1); idle(2);
        host_mode = 0; tok_pid = 4'h3;
        packet(8, -1); idle(2);

        // R2 / R5 / R4: oversize in host mode with both enables
        host_mode = 1; max_pkt = 4; tok_pid = 4'h9;
        packet(7, -1);
        // R8: next packet starts at offset 0
        rx_valid = 1; rx_eop = 0; lat_err = 0; #2;
        chk(mem_offset == 0, "R8", "offset at packet start", int'(mem_offset), 0);
        packet(3, -1); idle(2);

        // R3: a write of 0 keeps the flag, a write of 1 clears it
        stat_wr = 1; stat_wdata = 0; idle(1);
        stat_wdata = 1; idle(1);
        stat_wr = 0; idle(1);

        // R4: one enable off, oversize in device mode
        host_mode = 0; err_int_en = 0; tok_pid = 4'h5;
        packet(6, -1); idle(2);
        err_int_en = 1; dma_err_en = 0;
        packet(5, -1); idle(2);
        dma_err_en = 1;

        // R6: latency overrun in host mode, mid-packet and on the end byte
        host_mode = 1; max_pkt = 8; tok_pid = 4'h2;
        packet(5, 2); idle(2);
        packet(3, 2); idle(2);
        // latency between bytes of an unfinished packet
        cycle(1, 0, 0); cycle(0, 0, 1); cycle(1, 1, 0); idle(2);

        // R7: latency overrun in device mode
        host_mode = 0;
        packet(4, 1); idle(2);

        // R3: set and clear in the same cycle, set wins
        stat_wr = 1; stat_wdata = 1;
        packet(3, 2);
        stat_wr = 0; idle(2);
        chk(dma_err_stat == 1, "R3", "set beats clear", int'(dma_err_stat), 1);
        stat_wr = 1; idle(1); stat_wr = 0; idle(1);

        // R10: latency plus oversize, both modes
        max_pkt = 3; host_mode = 0; tok_pid = 4'hA;
        packet(6, 4); idle(2);
        host_mode = 1;
        packet(6, 1); idle(2);
        stat_wr = 1; idle(1); stat_wr = 0; idle(1);

        // R12: latency outside a packet is ignored
        max_pkt = 8; tok_pid = 4'h6;
        cycle(0, 0, 1); cycle(0, 0, 1);
        packet(3, -1); idle(2);
        chk(dma_err_stat == 0, "R12", "no error from idle overrun", int'(dma_err_stat), 0);

        // R1 extremes: size 0 and size 1, back-to-back one-byte packets
        max_pkt = 0; packet(3, -1); idle(1);
        max_pkt = 1; packet(1, -1); packet(1, -1); packet(4, -1); idle(2);
        stat_wr = 1; idle(1); stat_wr = 0;
        max_pkt = 8; host_mode = 0; packet(8, -1); packet(9, -1); idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule